// File: doc/BRIEF.md
# RTC Register Pointer and Snapshot Front End

This block sits between a byte-level serial-bus slave and the time-keeping core of a real-time clock. The bus side delivers one-cycle event pulses: start of a write transaction, start of a read transaction, a byte written by the host, and a byte taken by the host. The block keeps the register pointer and a shadow copy of the seven time bytes. Because of the shadow copy, a burst read returns one coherent moment even while the live counter keeps ticking.

Data bytes are routed by address. Writes to the seven time addresses go out on a loader strobe to the time core. Address 7 holds a control register. Addresses from the RAM base up to the register-space size are general storage. Reads of any other address return zero. Both the register-space size and the RAM base are parameters. `REG_SIZE` may be at most 64, and `RAM_START` must be at least 8.

The bus side must present the byte for the current pointer on `rdData` before it pulses `evRdByte`. When several events coincide, the priority is: start of write, then start of read, then byte written, then byte read.

Top module: `rtc_regfront`

## Requirements
- R1: After reset the pointer is 0, the address-pending flag is clear, and the shadow, control register and RAM all hold zero, so `rdData` and `ctrlOut` read 0x00.
- R2: The first byte written after a start-of-write loads the pointer with the byte modulo 64 (its low six bits). It is not stored and it does not advance the pointer. Later bytes in the same transaction are data.
- R3: Each data byte, written or read, advances the pointer by one. When the advanced value would reach `REG_SIZE`, the pointer becomes 0 instead.
- R4: A start of either kind copies `liveTime` into the shadow, with shadow byte k equal to `liveTime[8k+7:8k]`. The shadow keeps that copy until the next refresh.
- R5: The advance that wraps the pointer to 0 also copies `liveTime` into the shadow, on the same clock edge.
- R6: `rdData` shows the byte at the current pointer. Addresses 0 to 6 give shadow bytes, address 7 gives the control register, addresses `RAM_START` to `REG_SIZE-1` give RAM, and every other address gives 0x00.
- R7: A data write at addresses 0 to 6 raises `timeWrEn` in that same cycle, with `timeWrIdx` equal to the address and `timeWrData` equal to the byte. The shadow is left unchanged.
- R8: A data write at addresses `RAM_START` to `REG_SIZE-1` is stored. A data write at addresses 8 to `RAM_START-1`, or at `REG_SIZE` and above, changes nothing that can be read back.
- R9: A data write at address 7 stores the byte with bits 6, 3 and 2 forced to 0.
- R10: Control bit 5 is the oscillator-stop flag. `oscFail` sets it. A write of 0 to bit 5 clears it, a write of 1 to bit 5 leaves it unchanged, and `oscFail` wins over a clearing write in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| evStartWr | input | 1 | Start of a write transaction |
| evStartRd | input | 1 | Start of a read transaction |
| evWrByte | input | 1 | Host has written the byte on `wrData` |
| evRdByte | input | 1 | Host has taken the byte on `rdData` |
| wrData | input | 8 | Byte written by the host |
| liveTime | input | 56 | Running time, seven bytes, byte 0 in the low bits |
| oscFail | input | 1 | Oscillator-stop event, sets control bit 5 |
| rdData | output | 8 | Byte at the current pointer |
| timeWrEn | output | 1 | Load strobe to the time core |
| timeWrIdx | output | 3 | Time byte index for the load |
| timeWrData | output | 8 | Time byte value for the load |
| ctrlOut | output | 8 | Current control register |

## Verification
Some properties are checked every cycle by assertions. These cover how the pointer responds to a load, a step and a wrap. They also check that the shadow equals the sampled live time after every refresh, that the forced-zero control bits stay zero, and that the oscillator-stop flag never rises without `oscFail`. Other behaviour can only be shown by the bench scenarios, which compare against a behavioural model every clock. These include the address-region routing, reads of the gap and out-of-range addresses returning zero, and ignored writes leaving RAM untouched. They also include burst reads staying coherent while `liveTime` changes every cycle, and a wrap in the middle of a burst presenting freshly sampled time at address 0.

// File: rtl/rtc_regfront_pkg.sv
package rtc_regfront_pkg;
  localparam int ADDR_SPACE = 64;
  localparam int PTR_W      = $clog2(ADDR_SPACE);
  localparam int TIME_BYTES = 7;
  localparam int CTRL_ADDR  = 7;
  localparam logic [7:0] CTRL_KEEP_MASK = 8'hB3;
  localparam int OSF_BIT    = 5;

  typedef logic [PTR_W-1:0] ptr_t;

  typedef struct packed {
    logic snap;     // copy live time into shadow
    logic loadPtr;  // this byte is an address
    logic dataWr;   // this byte is data to store or route
    logic advance;  // pointer steps after a data byte
  } strobes_t;
endpackage

// File: rtl/rtc_regfront_ctrl.sv
module rtc_regfront_ctrl
  import rtc_regfront_pkg::*;
#(
  parameter int REG_SIZE = 64
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       evStartWr,
  input  logic       evStartRd,
  input  logic       evWrByte,
  input  logic       evRdByte,
  input  logic [7:0] wrData,
  output ptr_t       ptr,
  output strobes_t   strb
);
  localparam logic [PTR_W:0] SIZE_W = (PTR_W+1)'(REG_SIZE);

  logic           addrPend;
  logic           isStart;
  logic [PTR_W:0] ptrPlus;
  logic           wrapNow;

  always_comb begin
    isStart      = evStartWr | evStartRd;
    strb.loadPtr = !isStart && evWrByte && addrPend;
    strb.dataWr  = !isStart && evWrByte && !addrPend;
    strb.advance = strb.dataWr || (!isStart && !evWrByte && evRdByte);
    ptrPlus      = {1'b0, ptr} + (PTR_W+1)'(1);
    wrapNow      = strb.advance && (ptrPlus >= SIZE_W);
    strb.snap    = isStart || wrapNow;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ptr      <= '0;
      addrPend <= 1'b0;
    end else if (evStartWr) begin
      addrPend <= 1'b1;
    end else if (evStartRd) begin
      addrPend <= 1'b0;
    end else if (strb.loadPtr) begin
      ptr      <= wrData[PTR_W-1:0];
      addrPend <= 1'b0;
    end else if (strb.advance) begin
      ptr <= wrapNow ? '0 : ptrPlus[PTR_W-1:0];
    end
  end

  AST_PTR_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    strb.loadPtr |=> ptr == $past(wrData[PTR_W-1:0]));  // R2
  AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (strb.advance && !wrapNow) |=> ptr == ptr_t'($past(ptr) + 1'b1));  // R3
  AST_PTR_WRAP: assert property (@(posedge clk) disable iff (!rstN)
    wrapNow |=> ptr == '0);  // R3
endmodule

// File: rtl/rtc_regfront_data.sv
module rtc_regfront_data
  import rtc_regfront_pkg::*;
#(
  parameter int REG_SIZE  = 64,
  parameter int RAM_START = 8
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  ptr_t                  ptr,
  input  strobes_t              strb,
  input  logic [7:0]            wrData,
  input  logic [TIME_BYTES*8-1:0] liveTime,
  input  logic                  oscFail,
  output logic [7:0]            rdData,
  output logic                  timeWrEn,
  output logic [2:0]            timeWrIdx,
  output logic [7:0]            timeWrData,
  output logic [7:0]            ctrlOut
);
  logic [TIME_BYTES*8-1:0] shadowQ;
  logic [7:0]              ctrlQ;
  logic [7:0]              ctrlNext;
  logic [7:0]              cellQ [ADDR_SPACE];
  logic                    inTime;
  logic                    atCtrl;

  assign inTime = ptr < ptr_t'(TIME_BYTES);
  assign atCtrl = ptr == ptr_t'(CTRL_ADDR);

  // Shadow copy of the time bytes
  always_ff @(posedge clk) begin
    if (!rstN)          shadowQ <= '0;
    else if (strb.snap) shadowQ <= liveTime;
  end

  // Control register: masked bits and clear-only flag
  always_comb begin
    ctrlNext = ctrlQ;
    if (strb.dataWr && atCtrl) begin
      ctrlNext          = wrData & CTRL_KEEP_MASK;
      ctrlNext[OSF_BIT] = wrData[OSF_BIT] & ctrlQ[OSF_BIT];
    end
    if (oscFail) ctrlNext[OSF_BIT] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) ctrlQ <= '0;
    else       ctrlQ <= ctrlNext;
  end

  // Storage cells only for the RAM window
  for (genvar g = 0; g < ADDR_SPACE; g++) begin : gCell
    if (g >= RAM_START && g < REG_SIZE) begin : gRam
      logic [7:0] q;
      always_ff @(posedge clk) begin
        if (!rstN)                                   q <= '0;
        else if (strb.dataWr && ptr == PTR_W'(g))    q <= wrData;
      end
      assign cellQ[g] = q;
    end else begin : gNone
      assign cellQ[g] = 8'h00;
    end
  end

  always_comb begin
    if (inTime)      rdData = shadowQ[{ptr[2:0], 3'b000} +: 8];
    else if (atCtrl) rdData = ctrlQ;
    else             rdData = cellQ[ptr];
  end

  assign timeWrEn   = strb.dataWr && inTime;
  assign timeWrIdx  = ptr[2:0];
  assign timeWrData = wrData;
  assign ctrlOut    = ctrlQ;

  AST_SNAP_COPY: assert property (@(posedge clk) disable iff (!rstN)
    strb.snap |=> shadowQ == $past(liveTime));  // R4
  AST_SHADOW_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !strb.snap |=> $stable(shadowQ));  // R7
  AST_CTRL_RSVD: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlQ[6] == 1'b0) && (ctrlQ[3:2] == 2'b00));  // R9
  AST_OSF_NO_SET: assert property (@(posedge clk) disable iff (!rstN)
    (!oscFail && !ctrlQ[OSF_BIT]) |=> !ctrlQ[OSF_BIT]);  // R10
endmodule

// File: rtl/rtc_regfront.sv
module rtc_regfront
  import rtc_regfront_pkg::*;
#(
  parameter int REG_SIZE  = 64,
  parameter int RAM_START = 8
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        evStartWr,
  input  logic        evStartRd,
  input  logic        evWrByte,
  input  logic        evRdByte,
  input  logic [7:0]  wrData,
  input  logic [55:0] liveTime,
  input  logic        oscFail,
  output logic [7:0]  rdData,
  output logic        timeWrEn,
  output logic [2:0]  timeWrIdx,
  output logic [7:0]  timeWrData,
  output logic [7:0]  ctrlOut
);
  ptr_t     ptr;
  strobes_t strb;

  rtc_regfront_ctrl #(.REG_SIZE(REG_SIZE)) uCtrl (
    .clk(clk), .rstN(rstN),
    .evStartWr(evStartWr), .evStartRd(evStartRd),
    .evWrByte(evWrByte), .evRdByte(evRdByte),
    .wrData(wrData), .ptr(ptr), .strb(strb)
  );

  rtc_regfront_data #(.REG_SIZE(REG_SIZE), .RAM_START(RAM_START)) uData (
    .clk(clk), .rstN(rstN), .ptr(ptr), .strb(strb),
    .wrData(wrData), .liveTime(liveTime), .oscFail(oscFail),
    .rdData(rdData), .timeWrEn(timeWrEn), .timeWrIdx(timeWrIdx),
    .timeWrData(timeWrData), .ctrlOut(ctrlOut)
  );
endmodule

// File: tb/rtc_regfront_test.sv
module rtc_regfront_test;
  localparam int RS = 48;
  localparam int RB = 16;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic evStartWr = 0, evStartRd = 0, evWrByte = 0, evRdByte = 0, oscFail = 0;
  logic [7:0]  wrData = 0;
  logic [55:0] liveTime = 0;
  logic [7:0]  rdData, timeWrData, ctrlOut;
  logic        timeWrEn;
  logic [2:0]  timeWrIdx;

  int checks = 0, failures = 0;
  bit done = 0;

  // behavioural reference model
  int   mPtr;
  bit   mPend;
  logic [7:0] mShadow [7];
  logic [7:0] mRam [64];
  logic [7:0] mCtrl;

  always #10 clk = ~clk;

  rtc_regfront #(.REG_SIZE(RS), .RAM_START(RB)) uut (
    .clk(clk), .rstN(rstN), .evStartWr(evStartWr), .evStartRd(evStartRd),
    .evWrByte(evWrByte), .evRdByte(evRdByte), .wrData(wrData),
    .liveTime(liveTime), .oscFail(oscFail), .rdData(rdData),
    .timeWrEn(timeWrEn), .timeWrIdx(timeWrIdx), .timeWrData(timeWrData),
    .ctrlOut(ctrlOut)
  );

  function automatic logic [7:0] expRd();
    if (mPtr < 7) return mShadow[mPtr];
    if (mPtr == 7) return mCtrl;
    if (mPtr >= RB && mPtr < RS) return mRam[mPtr];
    return 8'h00;
  endfunction

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic modelReset();
    mPtr = 0; mPend = 0; mCtrl = 0;
    for (int i = 0; i < 7; i++) mShadow[i] = 0;
    for (int i = 0; i < 64; i++) mRam[i] = 0;
  endtask

  task automatic modelClock(input bit sw, input bit sr, input bit wb,
                            input bit rb, input logic [7:0] d,
                            input bit osc, input logic [55:0] lt);
    bit adv = 0, dwr = 0, snap = 0;
    if (sw || sr) snap = 1;
    if (!sw && !sr && wb && !mPend) dwr = 1;
    if (dwr || (!sw && !sr && !wb && rb)) adv = 1;
    if (dwr) begin
      if (mPtr == 7) begin
        logic [7:0] c;
        c = d & 8'hB3;
        c[5] = d[5] & mCtrl[5];
        mCtrl = c;
      end else if (mPtr >= RB && mPtr < RS) mRam[mPtr] = d;
    end
    if (osc) mCtrl[5] = 1'b1;
    if (sw) mPend = 1;
    else if (sr) mPend = 0;
    else if (wb && mPend) begin mPtr = d % 64; mPend = 0; end
    else if (adv) begin
      if (mPtr + 1 >= RS) begin mPtr = 0; snap = 1; end
      else mPtr = mPtr + 1;
    end
    if (snap) for (int k = 0; k < 7; k++) mShadow[k] = lt[8*k +: 8];
  endtask

  // one clock: drive, compare combinational outputs, clock, update model
  task automatic step(input string tag, input bit sw, input bit sr,
                      input bit wb, input bit rb, input logic [7:0] d,
                      input bit osc);
    logic [63:0] rnd;
    @(negedge clk);
    rnd = {$urandom(), $urandom()};
    evStartWr = sw; evStartRd = sr; evWrByte = wb; evRdByte = rb;
    wrData = d; oscFail = osc; liveTime = rnd[55:0];
    #1;
    chk(rdData === expRd(), tag, "rdData", rdData, expRd());
    chk(ctrlOut === mCtrl, tag, "ctrlOut", ctrlOut, mCtrl);
    begin
      bit expEn;
      expEn = wb && !sw && !sr && !mPend && mPtr < 7;
      chk(timeWrEn === expEn, tag, "timeWrEn", timeWrEn, expEn);
      if (expEn) begin
        chk(timeWrIdx === 3'(mPtr), tag, "timeWrIdx", timeWrIdx, mPtr);
        chk(timeWrData === d, tag, "timeWrData", timeWrData, d);
      end
    end
    @(posedge clk);
    modelClock(sw, sr, wb, rb, d, osc, liveTime);
  endtask

  task automatic idle(input string tag);        step(tag, 0, 0, 0, 0, 8'h00, 0); endtask
  task automatic startW(input string tag);      step(tag, 1, 0, 0, 0, 8'h00, 0); endtask
  task automatic startR(input string tag);      step(tag, 0, 1, 0, 0, 8'h00, 0); endtask
  task automatic wrB(input string tag, input logic [7:0] d); step(tag, 0, 0, 1, 0, d, 0); endtask
  task automatic rdB(input string tag);         step(tag, 0, 0, 0, 1, 8'h00, 0); endtask

  initial begin
    modelReset();
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1'b1;
    // R1: reset state
    #1;
    chk(rdData === 8'h00, "R1", "rdData after reset", rdData, 0);
    chk(ctrlOut === 8'h00, "R1", "ctrlOut after reset", ctrlOut, 0);
    idle("R1");

    // R4: burst read stays coherent while live time moves
    startR("R4");
    for (int i = 0; i < 7; i++) rdB("R4");
    rdB("R6");

    // R2: pointer load modulo 64, then R7 time write
    startW("R2");
    wrB("R2", 8'h45);
    wrB("R7", 8'h12);
    wrB("R7", 8'h34);
    startR("R2"); rdB("R6");

    // R8: RAM stores, R3/R5: wrap refreshes shadow
    startW("R8"); wrB("R2", 8'd46);
    wrB("R8", 8'hA5); wrB("R5", 8'h5A); wrB("R7", 8'h09);
    startW("R8"); wrB("R2", 8'd46);
    startR("R8"); rdB("R8"); rdB("R5"); rdB("R5"); rdB("R3");
    // read-driven wrap without an intervening START
    startW("R3"); wrB("R2", 8'd47); startR("R3");
    idle("R4");
    rdB("R5");
    for (int i = 0; i < 3; i++) rdB("R5");

    // R8: gap and out-of-range writes ignored
    startW("R8"); wrB("R2", 8'd9); wrB("R8", 8'hAA);
    startW("R8"); wrB("R2", 8'd9); idle("R8");
    startW("R8"); wrB("R2", 8'd60); wrB("R8", 8'h77);
    startW("R8"); wrB("R2", 8'd60); idle("R8"); idle("R6");
    startW("R6"); wrB("R2", 8'hFF); idle("R6");

    // R9/R10: control register
    step("R10", 0, 0, 0, 0, 8'h00, 1);
    idle("R10");
    startW("R9"); wrB("R2", 8'd7); wrB("R9", 8'hFF);
    startW("R9"); wrB("R2", 8'd7); idle("R9");
    wrB("R10", 8'h00); idle("R10");
    startW("R10"); wrB("R2", 8'd7); wrB("R10", 8'h20); idle("R10");
    startW("R10"); wrB("R2", 8'd7);
    step("R10", 0, 0, 1, 0, 8'h00, 1);
    idle("R10");
    repeat (2) idle("R6");

    @(negedge clk);
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule